// File: doc/BRIEF.md
# Prescaled Match/Capture Timer with PWM

This block is a general-purpose up-counting timer. A programmable prescale counter divides the peripheral clock, and the main counter advances by one each time the prescaler rolls over. Four compare channels watch the main counter. On each prescaler rollover a channel that equals the counter can raise a sticky flag, halt the counter, or send the counter back to zero. These actions can be enabled in any combination for each channel.

Compare channels 0 and 1 also drive an output pin. On a match, each pin can keep its level, go low, go high or toggle. Either pin can instead work as a single-edge PWM output. Its period comes from a pin-less channel set to reset the counter. The pin is low while the counter is below the channel's compare value and high from that value on.

A capture pin passes through a synchronizer. A selected edge on that pin copies the counter into a capture register and can raise a flag. Software reaches every setting through a flat register port: writes take effect at the clock edge, and reads are combinational.

Top module: `pmt_timer`

## Requirements
- R1: With the run bit set and the clear bit low, the prescale count (read-only, address 3) steps 0..L and wraps, where L is the prescale limit (address 1). The counter (address 2) gains one at each wrap, so it reads N after N*(L+1) clock edges.
- R2: Control register at address 0: bit 0 is run and bit 1 is clear. With run low the counter holds its value. With clear high, both the counter and the prescaler are forced to zero from the following edge. A write to address 2 loads the counter.
- R3: Compare values sit at addresses 4..7. Address 8 holds three bits per channel i: bit 3i is flag-enable, bit 3i+1 is halt and bit 3i+2 is zero. At a prescaler wrap where the counter equals channel i's value and flag-enable i is set, flag bit i goes high. Channels whose flag-enable is clear leave their flags low.
- R4: A matching channel with its zero bit set makes the counter read 0 after that wrap instead of value+1, so the counter cycles 0..M.
- R5: A matching channel with its halt bit set clears the run bit. The counter keeps the matched value and the prescaler keeps its count until run is written again.
- R6: Address 9 bits [2o+1:2o] select the match action of output pin o (o = 0, 1): 0 keep, 1 low, 2 high, 3 toggle. The action is applied at the same edge as the matching wrap of channel o. The pins read back at address 13 and reset low.
- R7: Address 9 bit 4+o puts pin o in PWM mode. The pin then equals (counter >= compare value o) in every cycle, so a compare value of 0 gives a constant high.
- R8: Address 10 holds rise-enable (bit 0), fall-enable (bit 1) and flag-enable (bit 2). A selected edge on the capture pin copies the counter into the capture register (address 11) three clock edges after the pin changes. If flag-enable is set, it also sets flag bit 4. Unselected edges change nothing.
- R9: Flags (address 12, bits 4:0, also on the flag port) are sticky. Writing a one to a bit clears it, and writing zero leaves it alone.
- R10: After reset, every register, the counter, the flags and both pins read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | peripheral clock |
| rst_ni | input | 1 | asynchronous active-low reset |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 4 | register write address |
| wr_data_i | input | 16 | register write data |
| rd_addr_i | input | 4 | register read address |
| rd_data_o | output | 16 | combinational read data |
| irq_flags_o | output | 5 | sticky flags: compare 0..3, capture |
| match_pin_o | output | 2 | match/PWM output pins |
| cap_pin_i | input | 1 | asynchronous capture input |

## Verification
Every result has a fixed latency from the write edge that starts a run. Counter values, pin actions, PWM levels and flags all change on the very edge of the prescaler wrap that causes them. A capture appears on the third edge after the capture pin moves. The bench drives and reads at falling edges and counts the rising edges since the enabling write. It checks each expected value on exactly the edge it is due, and it also checks that a capture has not yet happened one edge earlier.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    localparam int ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] A_PLIM   = 4'd1;
    localparam logic [ADDR_W-1:0] A_COUNT  = 4'd2;
    localparam logic [ADDR_W-1:0] A_PCNT   = 4'd3;
    localparam logic [ADDR_W-1:0] A_MATCH0 = 4'd4;
    localparam logic [ADDR_W-1:0] A_MCTL   = 4'd8;
    localparam logic [ADDR_W-1:0] A_OUTCTL = 4'd9;
    localparam logic [ADDR_W-1:0] A_CAPCTL = 4'd10;
    localparam logic [ADDR_W-1:0] A_CAPVAL = 4'd11;
    localparam logic [ADDR_W-1:0] A_FLAGS  = 4'd12;
    localparam logic [ADDR_W-1:0] A_PINS   = 4'd13;

    localparam int MCTL_STRIDE = 3;

    typedef enum logic [1:0] {
        PIN_KEEP   = 2'd0,
        PIN_LOW    = 2'd1,
        PIN_HIGH   = 2'd2,
        PIN_TOGGLE = 2'd3
    } pin_act_e;
endpackage

// File: rtl/pmt_prescale.sv
module pmt_prescale #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         run_i,
    input  logic         clr_i,
    input  logic [W-1:0] lim_i,
    output logic         tick_o,
    output logic [W-1:0] pcnt_o
);
    logic [W-1:0] pc_d, pc_q;
    logic         tick;

    always_comb begin
        pc_d = pc_q;
        tick = 1'b0;
        if (clr_i) begin
            pc_d = '0;
        end else if (run_i) begin
            if (pc_q >= lim_i) begin
                pc_d = '0;
                tick = 1'b1;
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pc_q <= '0;
        else         pc_q <= pc_d;
    end

    assign tick_o = tick;
    assign pcnt_o = pc_q;

    // R1
    tick_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> (pcnt_o == '0));

    // R1
    pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_i && !clr_i && !tick_o) |=> (pcnt_o == $past(pcnt_o) + 1'b1));

    // R5
    pc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!run_i && !clr_i) |=> $stable(pcnt_o));
endmodule

// File: rtl/pmt_capsync.sv
module pmt_capsync (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic rise_en_i,
    input  logic fall_en_i,
    output logic evt_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = pin_i;
        sync_d.s2 = sync_q.s1;
        sync_d.s3 = sync_q.s2;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '0;
        else         sync_q <= sync_d;
    end

    assign evt_o = (rise_en_i && sync_q.s2 && !sync_q.s3)
                || (fall_en_i && !sync_q.s2 && sync_q.s3);
endmodule

// File: rtl/pmt_pin.sv
module pmt_pin #(
    parameter int W = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         hit_i,
    input  logic [1:0]   act_i,
    input  logic         pwm_i,
    input  logic [W-1:0] cnt_nx_i,
    input  logic [W-1:0] mval_nx_i,
    output logic         pin_o
);
    import pmt_pkg::*;

    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (pwm_i) begin
            pin_d = (cnt_nx_i >= mval_nx_i);
        end else if (hit_i) begin
            case (pin_act_e'(act_i))
                PIN_LOW:    pin_d = 1'b0;
                PIN_HIGH:   pin_d = 1'b1;
                PIN_TOGGLE: pin_d = ~pin_q;
                default:    pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pin_q <= 1'b0;
        else         pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    // R6
    pin_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_i && hit_i && act_i == PIN_HIGH) |=> pin_o);

    // R6
    pin_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_i && hit_i && act_i == PIN_LOW) |=> !pin_o);

    // R6
    pin_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_i && hit_i && act_i == PIN_TOGGLE) |=> (pin_o != $past(pin_o)));

    // R6
    pin_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!pwm_i && !hit_i) |=> $stable(pin_o));
endmodule

// File: rtl/pmt_timer.sv
module pmt_timer #(
    parameter int CNT_W   = 16,
    parameter int N_MATCH = 4,
    parameter int N_OUT   = 2
) (
    input  logic                           clk_i,
    input  logic                           rst_ni,
    input  logic                           wr_en_i,
    input  logic [pmt_pkg::ADDR_W-1:0]     wr_addr_i,
    input  logic [CNT_W-1:0]               wr_data_i,
    input  logic [pmt_pkg::ADDR_W-1:0]     rd_addr_i,
    output logic [CNT_W-1:0]               rd_data_o,
    output logic [N_MATCH:0]               irq_flags_o,
    output logic [N_OUT-1:0]               match_pin_o,
    input  logic                           cap_pin_i
);
    import pmt_pkg::*;

    localparam int FLAG_W  = N_MATCH + 1;
    localparam int PWM_OFS = 2 * N_OUT;

    typedef struct packed {
        logic                          en;
        logic                          clr;
        logic [CNT_W-1:0]              plim;
        logic [CNT_W-1:0]              cnt;
        logic [N_MATCH-1:0][CNT_W-1:0] mval;
        logic [N_MATCH-1:0]            m_irq;
        logic [N_MATCH-1:0]            m_stop;
        logic [N_MATCH-1:0]            m_rst;
        logic [N_OUT-1:0][1:0]         act;
        logic [N_OUT-1:0]              pwm;
        logic                          cap_rise;
        logic                          cap_fall;
        logic                          cap_irq;
        logic [CNT_W-1:0]              cap_val;
        logic [FLAG_W-1:0]             flags;
    } regs_t;

    regs_t q, d;

    logic               tick;
    logic [CNT_W-1:0]   pcnt;
    logic               cap_evt;
    logic [N_MATCH-1:0] hit;
    logic               rst_hit, stop_hit;
    logic               wr_ctrl, wr_cnt, wr_flags;
    logic [FLAG_W-1:0]  clr_mask;
    logic [N_OUT-1:0]   pins;
    logic [CNT_W-1:0]   rd;

    // compare channels are only evaluated on a prescaler wrap
    always_comb begin
        for (int i = 0; i < N_MATCH; i++) begin
            hit[i] = tick && (q.cnt == q.mval[i]);
        end
    end

    assign rst_hit  = |(hit & q.m_rst);
    assign stop_hit = |(hit & q.m_stop);
    assign wr_ctrl  = wr_en_i && (wr_addr_i == A_CTRL);
    assign wr_cnt   = wr_en_i && (wr_addr_i == A_COUNT);
    assign wr_flags = wr_en_i && (wr_addr_i == A_FLAGS);
    assign clr_mask = wr_flags ? wr_data_i[FLAG_W-1:0] : '0;

    pmt_prescale #(.W(CNT_W)) u_presc (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (q.en && !q.clr),
        .clr_i  (q.clr),
        .lim_i  (q.plim),
        .tick_o (tick),
        .pcnt_o (pcnt)
    );

    pmt_capsync u_cap (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .pin_i     (cap_pin_i),
        .rise_en_i (q.cap_rise),
        .fall_en_i (q.cap_fall),
        .evt_o     (cap_evt)
    );

    always_comb begin
        d = q;

        if (wr_ctrl) begin
            d.en  = wr_data_i[0];
            d.clr = wr_data_i[1];
        end else if (stop_hit) begin
            d.en = 1'b0;
        end

        if (wr_en_i && wr_addr_i == A_PLIM) d.plim = wr_data_i;

        if (q.clr) begin
            d.cnt = '0;
        end else if (wr_cnt) begin
            d.cnt = wr_data_i;
        end else if (tick) begin
            if (rst_hit)        d.cnt = '0;
            else if (!stop_hit) d.cnt = q.cnt + 1'b1;
        end

        for (int i = 0; i < N_MATCH; i++) begin
            if (wr_en_i && wr_addr_i == ADDR_W'(int'(A_MATCH0) + i)) d.mval[i] = wr_data_i;
        end

        if (wr_en_i && wr_addr_i == A_MCTL) begin
            for (int i = 0; i < N_MATCH; i++) begin
                d.m_irq[i]  = wr_data_i[MCTL_STRIDE*i];
                d.m_stop[i] = wr_data_i[MCTL_STRIDE*i+1];
                d.m_rst[i]  = wr_data_i[MCTL_STRIDE*i+2];
            end
        end

        if (wr_en_i && wr_addr_i == A_OUTCTL) begin
            for (int o = 0; o < N_OUT; o++) begin
                d.act[o] = wr_data_i[2*o +: 2];
                d.pwm[o] = wr_data_i[PWM_OFS+o];
            end
        end

        if (wr_en_i && wr_addr_i == A_CAPCTL) begin
            d.cap_rise = wr_data_i[0];
            d.cap_fall = wr_data_i[1];
            d.cap_irq  = wr_data_i[2];
        end

        if (cap_evt) d.cap_val = q.cnt;

        // a new event wins over a clear in the same cycle
        d.flags = (q.flags & ~clr_mask) | {cap_evt && q.cap_irq, hit & q.m_irq};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    for (genvar o = 0; o < N_OUT; o++) begin : g_pin
        pmt_pin #(.W(CNT_W)) u_pin (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .hit_i     (hit[o]),
            .act_i     (q.act[o]),
            .pwm_i     (d.pwm[o]),
            .cnt_nx_i  (d.cnt),
            .mval_nx_i (d.mval[o]),
            .pin_o     (pins[o])
        );

        // R7
        pwm_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            q.pwm[o] |-> (pins[o] == (q.cnt >= q.mval[o])));
    end

    for (genvar i = 0; i < N_MATCH; i++) begin : g_flag
        // R3
        match_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (hit[i] && q.m_irq[i]) |=> irq_flags_o[i]);
    end

    always_comb begin
        rd = '0;
        case (rd_addr_i)
            A_CTRL:  rd[1:0] = {q.clr, q.en};
            A_PLIM:  rd = q.plim;
            A_COUNT: rd = q.cnt;
            A_PCNT:  rd = pcnt;
            A_MCTL: begin
                for (int i = 0; i < N_MATCH; i++) begin
                    rd[MCTL_STRIDE*i +: MCTL_STRIDE] = {q.m_rst[i], q.m_stop[i], q.m_irq[i]};
                end
            end
            A_OUTCTL: begin
                for (int o = 0; o < N_OUT; o++) begin
                    rd[2*o +: 2]   = q.act[o];
                    rd[PWM_OFS+o]  = q.pwm[o];
                end
            end
            A_CAPCTL: rd[2:0] = {q.cap_irq, q.cap_fall, q.cap_rise};
            A_CAPVAL: rd = q.cap_val;
            A_FLAGS:  rd[FLAG_W-1:0] = q.flags;
            A_PINS:   rd[N_OUT-1:0] = pins;
            default:  rd = '0;
        endcase
        for (int i = 0; i < N_MATCH; i++) begin
            if (rd_addr_i == ADDR_W'(int'(A_MATCH0) + i)) rd = q.mval[i];
        end
    end

    assign rd_data_o   = rd;
    assign irq_flags_o = q.flags;
    assign match_pin_o = pins;

    // R4
    rst_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rst_hit && !wr_cnt) |=> (q.cnt == '0));

    // R5
    stop_on_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stop_hit && !wr_ctrl) |=> !q.en);

    // R2
    hold_when_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!q.en && !q.clr && !wr_cnt) |=> $stable(q.cnt));

    // R8
    capture_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_evt |=> (q.cap_val == $past(q.cnt)));

    // R9
    flag_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((irq_flags_o & $past(irq_flags_o & ~clr_mask)) == $past(irq_flags_o & ~clr_mask)));
endmodule

// File: tb/pmt_timer_tb.sv
module pmt_timer_tb_top;
    import pmt_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [3:0]  rd_addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic [4:0]  flags;
    logic [1:0]  pins;
    logic        cap = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pmt_timer dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (wr_addr),
        .wr_data_i   (wr_data),
        .rd_addr_i   (rd_addr),
        .rd_data_o   (rd_data),
        .irq_flags_o (flags),
        .match_pin_o (pins),
        .cap_pin_i   (cap)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // called at a falling edge; the write lands on the next rising edge
    task automatic wr(input logic [3:0] a, input logic [15:0] v);
        wr_en = 1'b1; wr_addr = a; wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic apply(input int act, input logic cur);
        case (act)
            1: return 1'b0;
            2: return 1'b1;
            3: return ~cur;
            default: return cur;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1..R10 run actual timeout expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        rd(A_CTRL, v);   check("R10 ctrl", v, 0);
        rd(A_COUNT, v);  check("R10 count", v, 0);
        rd(A_PLIM, v);   check("R10 plim", v, 0);
        rd(A_MCTL, v);   check("R10 mctl", v, 0);
        check("R10 flags", flags, 0);
        check("R10 pins", pins, 0);

        // R1 prescale sweep
        for (int ps = 0; ps < 4; ps++) begin
            wr(A_CTRL, 16'h2);
            wr(A_PLIM, 16'(ps));
            wr(A_CTRL, 16'h1);
            repeat (5 * (ps + 1)) @(negedge clk);
            rd(A_COUNT, v); check("R1 count after N periods", v, 5);
            rd(A_PCNT, v);  check("R1 prescale wrapped", v, 0);
        end
        wr(A_PLIM, 16'h0);

        // R2 run, load and clear
        wr(A_CTRL, 16'h0);
        wr(A_COUNT, 16'h0100);
        rd(A_COUNT, v); check("R2 load", v, 16'h0100);
        repeat (5) @(negedge clk);
        rd(A_COUNT, v); check("R2 hold while off", v, 16'h0100);
        wr(A_CTRL, 16'h2);
        @(negedge clk);
        rd(A_COUNT, v); check("R2 clear", v, 0);
        wr(A_CTRL, 16'h0);

        // R3 R4 R9 flag + zero-on-match sweep
        wr(A_MCTL, 16'h0005);
        wr(A_OUTCTL, 16'h0);
        for (int idx = 0; idx < 3; idx++) begin
            int m;
            m = (idx == 0) ? 1 : (idx == 1) ? 2 : 4;
            wr(A_CTRL, 16'h2);
            wr(A_FLAGS, 16'h1F);
            wr(A_MATCH0, 16'(m));
            wr(A_CTRL, 16'h1);
            for (int k = 1; k <= 2 * m + 2; k++) begin
                @(negedge clk);
                rd(A_COUNT, v);
                check("R4 count wraps at match", v, k % (m + 1));
                check("R3 flag0", flags[0], (k >= m + 1) ? 1 : 0);
            end
            wr(A_CTRL, 16'h0);
            check("R3 other flags low", flags[4:1], 0);
            wr(A_FLAGS, 16'h0);
            check("R9 zero write keeps flag", flags[0], 1);
            repeat (3) @(negedge clk);
            check("R9 sticky", flags[0], 1);
            wr(A_FLAGS, 16'h1);
            check("R9 one write clears", flags[0], 0);
        end

        // R5 halt on match with prescale 1
        wr(A_CTRL, 16'h2);
        wr(A_FLAGS, 16'h1F);
        wr(A_PLIM, 16'h1);
        wr(A_MCTL, 16'h0010);
        wr(A_MATCH0 + 4'd1, 16'h4);
        wr(A_CTRL, 16'h1);
        repeat (9) @(negedge clk);
        rd(A_COUNT, v); check("R5 reached match", v, 4);
        rd(A_CTRL, v);  check("R5 still running", v, 1);
        @(negedge clk);
        rd(A_CTRL, v);  check("R5 run cleared", v, 0);
        repeat (20) @(negedge clk);
        rd(A_COUNT, v); check("R5 count held", v, 4);
        rd(A_PCNT, v);  check("R5 prescale held", v, 0);
        wr(A_PLIM, 16'h0);

        // R6 pin action sweep: ch0 at 2, ch1 at 4, ch3 zeroes at 5
        wr(A_MCTL, 16'h0800);
        wr(A_MATCH0, 16'h2);
        wr(A_MATCH0 + 4'd1, 16'h4);
        wr(A_MATCH0 + 4'd3, 16'h5);
        for (int a0 = 0; a0 < 4; a0++) begin
            for (int a1 = 0; a1 < 4; a1++) begin
                logic e0, e1;
                wr(A_CTRL, 16'h2);
                wr(A_OUTCTL, 16'(a0 | (a1 << 2)));
                e0 = pins[0];
                e1 = pins[1];
                wr(A_CTRL, 16'h1);
                for (int k = 1; k <= 13; k++) begin
                    @(negedge clk);
                    if (k % 6 == 3) e0 = apply(a0, e0);
                    if (k % 6 == 5) e1 = apply(a1, e1);
                    #1;
                    check("R6 pin0 action", pins[0], e0);
                    check("R6 pin1 action", pins[1], e1);
                end
                wr(A_CTRL, 16'h0);
            end
        end
        rd(A_PINS, v); check("R6 pin readback", v, pins);

        // R7 PWM sweep over compare values, period 6
        wr(A_OUTCTL, 16'h0010);
        for (int m = 0; m <= 6; m++) begin
            wr(A_CTRL, 16'h2);
            wr(A_MATCH0, 16'(m));
            wr(A_CTRL, 16'h1);
            for (int k = 1; k <= 12; k++) begin
                @(negedge clk);
                #1;
                check("R7 pwm level", pins[0], ((k % 6) >= m) ? 1 : 0);
            end
            wr(A_CTRL, 16'h0);
        end
        wr(A_OUTCTL, 16'h0);

        // R8 capture edge selection sweep
        wr(A_CTRL, 16'h0);
        for (int sel = 1; sel < 4; sel++) begin
            wr(A_CAPCTL, 16'(sel | 4));
            for (int t = 0; t < 2; t++) begin
                logic [15:0] prev, cv;
                bit selected;
                cv = 16'h1000 + 16'(sel * 16 + t);
                wr(A_COUNT, cv);
                wr(A_FLAGS, 16'h10);
                rd(A_CAPVAL, prev);
                selected = (t == 0) ? sel[0] : sel[1];
                cap = ~cap;
                repeat (2) @(negedge clk);
                rd(A_CAPVAL, v); check("R8 not yet captured", v, prev);
                @(negedge clk);
                rd(A_CAPVAL, v); check("R8 capture value", v, selected ? cv : prev);
                check("R8 capture flag", flags[4], selected ? 1 : 0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule